// File: doc/BRIEF.md
# Instruction Filter Cache with Miss-Route Prediction

This block is a small direct-mapped instruction store that sits between a processor's fetch port and a larger level-one instruction cache. Most fetches are answered from its own 256-byte array, so the larger cache stays idle. Each line carries a one-bit route flag. The flag decides, before the array is touched, whether a fetch probes the small array or is routed straight to the level-one cache.

A fetch predicted to miss skips the probe. It therefore pays no extra cycle for a lookup that would fail. Every line that comes back from the level-one cache is written into the small array, whichever path requested it. Three counters of hits, probe misses and routed-around fetches are available as output ports.

The core side is a valid/ready request with a one-cycle response pulse. The level-one side is a one-cycle line request with a one-cycle line response, and only one request is outstanding at a time.

Top module: `fetch_filter_cache`

## Requirements
- R1: After reset, core_req_ready is high, core_resp_valid and l1_req_valid are low, all three counters read zero, every line is invalid, and every route flag is clear.
- R2: The fetch address is split into a byte offset [3:0], a word select [3:2], a line index [7:4] and a tag [31:8]. The returned word is 32-bit word number addr[3:2] of the 16-byte line, where word k occupies line bits [32k+31:32k].
- R3: A line's route flag is set when a routed-around fetch refills that line, and cleared when a probe misses and refills it. A probe hit leaves it set. A fetch whose flag is clear is routed around even when its line is resident.
- R4: A fetch whose flag is set and whose line is valid with a matching tag raises core_resp_valid in the second cycle after the acceptance edge, and raises no level-one request.
- R5: A fetch whose flag is set but which misses raises l1_req_valid in the second cycle after acceptance. It raises core_resp_valid in the cycle after the edge that samples l1_resp_valid.
- R6: A fetch whose flag is clear raises l1_req_valid in the first cycle after acceptance, without probing the array. It is counted as a bypass.
- R7: Every level-one response writes the line, its tag and its valid bit. A later fetch to that line with a set flag is then a hit.
- R8: l1_req_addr is line aligned (bits [3:0] zero), and l1_req_valid lasts exactly one cycle per request.
- R9: core_req_ready is low from acceptance until the response cycle. Requests offered while it is low are ignored, and core_req_ready is high in the response cycle.
- R10: hit_count, miss_count and bypass_count each rise by exactly one for each hit, probe miss and routed-around fetch respectively.
- R11: core_resp_valid is a single-cycle pulse per accepted fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Fetch request valid |
| core_req_addr | input | 32 | Fetch byte address |
| core_req_ready | output | 1 | Block can accept a fetch |
| core_resp_valid | output | 1 | Fetched word valid (one cycle) |
| core_resp_data | output | 32 | Fetched instruction word |
| l1_req_valid | output | 1 | Line request to level-one cache (one cycle) |
| l1_req_addr | output | 32 | Line-aligned request address |
| l1_resp_valid | input | 1 | Line response valid |
| l1_resp_line | input | 128 | Returned 16-byte line |
| hit_count | output | 16 | Probe hits |
| miss_count | output | 16 | Probe misses |
| bypass_count | output | 16 | Fetches routed straight to level one |

## Verification
Cycles are counted from the acceptance edge, so cycle 1 is the first cycle after it. A hit responds in cycle 2, a routed-around fetch requests a line in cycle 1, and a probe miss requests a line in cycle 2. The core response follows one cycle after the edge that samples the level-one reply. The bench acts as the level-one cache with a fixed two-cycle latency. It samples every output at the falling edge, records the exact cycle at which each request and each response appears, and compares those cycles with the numbers above. It also compares the returned word with the word its own line model computes and compares the counters after each scenario.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WAIT   = 2'd2
  } ffc_state_e;

  localparam int CNT_HIT  = 0;
  localparam int CNT_MISS = 1;
  localparam int CNT_BYP  = 2;
  localparam int NUM_CNT  = 3;

endpackage

// File: rtl/ffc_data_ram.sv
module ffc_data_ram #(
  parameter int LINE_W = 128,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [LINE_W-1:0] rdata
);

  logic [LINE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/ffc_tag_store.sv
module ffc_tag_store #(
  parameter int TAG_W     = 24,
  parameter int NUM_LINES = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] route_idx,
  output logic             route_flag,
  input  logic [IDX_W-1:0] look_idx,
  output logic [TAG_W-1:0] look_tag,
  output logic             look_valid,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_flag
);

  logic [TAG_W-1:0] tag_q [NUM_LINES];
  logic [NUM_LINES-1:0] vld_q;
  logic [NUM_LINES-1:0] flg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      flg_q <= '0;
    end else if (fill_en) begin
      vld_q[fill_idx] <= 1'b1;
      flg_q[fill_idx] <= fill_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign route_flag = flg_q[route_idx];
  assign look_tag   = tag_q[look_idx];
  assign look_valid = vld_q[look_idx];

endmodule

// File: rtl/ffc_counter.sv
module ffc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/fetch_filter_cache.sv
module fetch_filter_cache
  import ffc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 16,
  parameter int CNT_W      = 16,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req_valid,
  input  logic [ADDR_W-1:0] core_req_addr,
  output logic              core_req_ready,
  output logic              core_resp_valid,
  output logic [WORD_W-1:0] core_resp_data,
  output logic              l1_req_valid,
  output logic [ADDR_W-1:0] l1_req_addr,
  input  logic              l1_resp_valid,
  input  logic [LINE_W-1:0] l1_resp_line,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  bypass_count
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BYTE_W;

  ffc_state_e state_q;

  logic [TAG_W-1:0]  cur_tag_q;
  logic [IDX_W-1:0]  cur_idx_q;
  logic [WSEL_W-1:0] cur_wsel_q;
  logic              cur_byp_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              unused_byte_bits;

  assign req_tag  = core_req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = core_req_addr[OFF_W +: IDX_W];
  assign req_wsel = core_req_addr[BYTE_W +: WSEL_W];
  assign unused_byte_bits = ^core_req_addr[BYTE_W-1:0];

  logic              route_flag;
  logic [TAG_W-1:0]  look_tag;
  logic              look_valid;
  logic [LINE_W-1:0] ram_q;
  logic              accept;
  logic              probe_rd;
  logic              probe_hit;
  logic              fill_en;

  assign core_req_ready = (state_q == ST_IDLE);
  assign accept    = core_req_valid && core_req_ready;
  assign probe_rd  = accept && route_flag;
  assign probe_hit = (state_q == ST_LOOKUP) && look_valid && (look_tag == cur_tag_q);
  assign fill_en   = (state_q == ST_WAIT) && l1_resp_valid;

  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [WSEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction

  ffc_tag_store #(
    .TAG_W     (TAG_W),
    .NUM_LINES (NUM_LINES)
  ) u_tags (
    .clk        (clk),
    .rst        (rst),
    .route_idx  (req_idx),
    .route_flag (route_flag),
    .look_idx   (cur_idx_q),
    .look_tag   (look_tag),
    .look_valid (look_valid),
    .fill_en    (fill_en),
    .fill_idx   (cur_idx_q),
    .fill_tag   (cur_tag_q),
    .fill_flag  (cur_byp_q)
  );

  ffc_data_ram #(
    .LINE_W (LINE_W),
    .DEPTH  (NUM_LINES)
  ) u_data (
    .clk   (clk),
    .we    (fill_en),
    .waddr (cur_idx_q),
    .wdata (l1_resp_line),
    .re    (probe_rd),
    .raddr (req_idx),
    .rdata (ram_q)
  );

  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  assign inc_vec[CNT_HIT]  = probe_hit;
  assign inc_vec[CNT_MISS] = (state_q == ST_LOOKUP) && !probe_hit;
  assign inc_vec[CNT_BYP]  = accept && !route_flag;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ffc_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc_vec[g]),
      .count (cnt_arr[g])
    );
  end

  assign hit_count    = cnt_arr[CNT_HIT];
  assign miss_count   = cnt_arr[CNT_MISS];
  assign bypass_count = cnt_arr[CNT_BYP];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q         <= ST_IDLE;
      cur_tag_q       <= '0;
      cur_idx_q       <= '0;
      cur_wsel_q      <= '0;
      cur_byp_q       <= 1'b0;
      l1_req_valid    <= 1'b0;
      l1_req_addr     <= '0;
      core_resp_valid <= 1'b0;
      core_resp_data  <= '0;
    end else begin
      l1_req_valid    <= 1'b0;
      core_resp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cur_tag_q  <= req_tag;
            cur_idx_q  <= req_idx;
            cur_wsel_q <= req_wsel;
            cur_byp_q  <= !route_flag;
            if (route_flag) begin
              state_q <= ST_LOOKUP;
            end else begin
              l1_req_valid <= 1'b1;
              l1_req_addr  <= {req_tag, req_idx, {OFF_W{1'b0}}};
              state_q      <= ST_WAIT;
            end
          end
        end
        ST_LOOKUP: begin
          if (probe_hit) begin
            core_resp_valid <= 1'b1;
            core_resp_data  <= pick_word(ram_q, cur_wsel_q);
            state_q         <= ST_IDLE;
          end else begin
            l1_req_valid <= 1'b1;
            l1_req_addr  <= {cur_tag_q, cur_idx_q, {OFF_W{1'b0}}};
            state_q      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (l1_resp_valid) begin
            core_resp_valid <= 1'b1;
            core_resp_data  <= pick_word(l1_resp_line, cur_wsel_q);
            state_q         <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ffc_checker.sv
module ffc_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int CNT_W      = 16,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              core_req_ready,
  input logic              core_resp_valid,
  input logic              l1_req_valid,
  input logic [ADDR_W-1:0] l1_req_addr,
  input logic              l1_resp_valid,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic [CNT_W-1:0]  bypass_count
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hit_count == '0 && miss_count == '0 && bypass_count == '0 && core_req_ready)); // R1

  AST_L1_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    l1_req_valid |=> !l1_req_valid); // R8

  AST_L1_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    l1_req_valid |-> (l1_req_addr[OFF_W-1:0] == '0)); // R8

  AST_BUSY_DURING_L1: assert property (@(posedge clk) disable iff (rst)
    l1_req_valid |-> !core_req_ready); // R9

  AST_READY_AT_RESP: assert property (@(posedge clk) disable iff (rst)
    core_resp_valid |-> core_req_ready); // R9

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    core_resp_valid |=> !core_resp_valid); // R11

  AST_REFILL_TO_RESP: assert property (@(posedge clk) disable iff (rst)
    (l1_resp_valid && !core_req_ready) |=> core_resp_valid); // R5

  AST_HIT_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (hit_count == $past(hit_count) || hit_count == $past(hit_count) + 1'b1)); // R10

  AST_MISS_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1)); // R10

  AST_BYP_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (bypass_count == $past(bypass_count) || bypass_count == $past(bypass_count) + 1'b1)); // R10

endmodule

bind fetch_filter_cache ffc_checker #(
  .ADDR_W     (ADDR_W),
  .LINE_BYTES (LINE_BYTES),
  .CNT_W      (CNT_W)
) u_ffc_checker (
  .clk             (clk),
  .rst             (rst),
  .core_req_ready  (core_req_ready),
  .core_resp_valid (core_resp_valid),
  .l1_req_valid    (l1_req_valid),
  .l1_req_addr     (l1_req_addr),
  .l1_resp_valid   (l1_resp_valid),
  .hit_count       (hit_count),
  .miss_count      (miss_count),
  .bypass_count    (bypass_count)
);

// File: tb/tb_fetch_filter_cache.sv
`timescale 1ns/1ps
module tb_fetch_filter_cache;

  localparam int LAT = 2;
  localparam int K_HIT = 0;
  localparam int K_BYP = 1;
  localparam int K_MISS = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         core_req_valid = 1'b0;
  logic [31:0]  core_req_addr = '0;
  logic         core_req_ready;
  logic         core_resp_valid;
  logic [31:0]  core_resp_data;
  logic         l1_req_valid;
  logic [31:0]  l1_req_addr;
  logic         l1_resp_valid = 1'b0;
  logic [127:0] l1_resp_line = '0;
  logic [15:0]  hit_count, miss_count, bypass_count;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_filter_cache dut (
    .clk(clk), .rst(rst),
    .core_req_valid(core_req_valid), .core_req_addr(core_req_addr),
    .core_req_ready(core_req_ready), .core_resp_valid(core_resp_valid),
    .core_resp_data(core_resp_data), .l1_req_valid(l1_req_valid),
    .l1_req_addr(l1_req_addr), .l1_resp_valid(l1_resp_valid),
    .l1_resp_line(l1_resp_line), .hit_count(hit_count),
    .miss_count(miss_count), .bypass_count(bypass_count)
  );

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] base);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = word_of({base[31:4], 4'h0} + 32'(4*k));
    return l;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic check_counts(input string req, input int eh, input int em, input int eb);
    chk(hit_count == 16'(eh), req, "hit_count", 32'(hit_count), 32'(eh));
    chk(miss_count == 16'(em), req, "miss_count", 32'(miss_count), 32'(em));
    chk(bypass_count == 16'(eb), req, "bypass_count", 32'(bypass_count), 32'(eb));
  endtask

  // One fetch; the bench plays the level-one cache with LAT cycles of latency.
  task automatic do_fetch(input logic [31:0] a, input int kind, input string req,
                          input bit stray);
    int l1_seen = -100;
    int resp_cyc = -1;
    int l1_reqs = 0;
    logic [31:0] l1_a = '0;
    logic [31:0] data = '0;
    int exp_l1;
    int exp_resp;
    @(negedge clk);
    chk(core_req_ready, req, "ready before fetch", 32'(core_req_ready), 32'd1);
    core_req_valid = 1'b1;
    core_req_addr  = a;
    @(negedge clk);
    core_req_valid = 1'b0;
    for (int cyc = 1; cyc < 40; cyc++) begin
      if (stray && cyc == 1) begin
        core_req_valid = 1'b1;
        core_req_addr  = 32'h0000_1234;
        chk(!core_req_ready, "R9", "ready while busy", 32'(core_req_ready), 32'd0);
      end else if (stray && cyc == 2) begin
        core_req_valid = 1'b0;
      end
      if (l1_req_valid) begin
        l1_seen = cyc;
        l1_reqs++;
        l1_a = l1_req_addr;
      end
      if (cyc == l1_seen + LAT) begin
        l1_resp_valid = 1'b1;
        l1_resp_line  = line_of(l1_a);
      end else begin
        l1_resp_valid = 1'b0;
      end
      if (core_resp_valid) begin
        resp_cyc = cyc;
        data = core_resp_data;
        break;
      end
      @(negedge clk);
    end
    l1_resp_valid = 1'b0;
    exp_l1   = (kind == K_HIT) ? -100 : (kind == K_BYP ? 1 : 2);
    exp_resp = (kind == K_HIT) ? 2 : exp_l1 + LAT + 1;
    chk(l1_seen == exp_l1, req, "l1 request cycle", 32'(l1_seen), 32'(exp_l1));
    chk(l1_reqs == ((kind == K_HIT) ? 0 : 1), req, "l1 request count", 32'(l1_reqs),
        (kind == K_HIT) ? 32'd0 : 32'd1);
    if (kind != K_HIT)
      chk(l1_a == {a[31:4], 4'h0}, "R8", "l1 address aligned", l1_a, {a[31:4], 4'h0});
    chk(resp_cyc == exp_resp, req, "response cycle", 32'(resp_cyc), 32'(exp_resp));
    chk(data == word_of(a), "R2", "returned word", data, word_of(a));
    @(negedge clk);
    chk(!core_resp_valid, "R11", "response is one pulse", 32'(core_resp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk(core_req_ready, "R1", "ready after reset", 32'(core_req_ready), 32'd1);
    chk(!core_resp_valid, "R1", "resp after reset", 32'(core_resp_valid), 32'd0);
    chk(!l1_req_valid, "R1", "l1 req after reset", 32'(l1_req_valid), 32'd0);
    check_counts("R1", 0, 0, 0);
  endtask

  task automatic t_cold_and_hit();
    do_fetch(32'h0000_1234, K_BYP, "R6", 1'b0);
    check_counts("R10", 0, 0, 1);
    do_fetch(32'h0000_123C, K_HIT, "R4", 1'b0);
    check_counts("R10", 1, 0, 1);
  endtask

  task automatic t_conflict_and_route();
    do_fetch(32'h0000_5238, K_MISS, "R5", 1'b0);
    check_counts("R10", 1, 1, 1);
    do_fetch(32'h0000_5230, K_BYP, "R3", 1'b0);
    check_counts("R10", 1, 1, 2);
    do_fetch(32'h0000_5234, K_HIT, "R7", 1'b0);
    do_fetch(32'h0000_1234, K_MISS, "R3", 1'b0);
    check_counts("R10", 2, 2, 2);
  endtask

  task automatic t_index_edges();
    do_fetch(32'hFFFF_FFF0, K_BYP, "R2", 1'b0);
    do_fetch(32'h0000_0100, K_BYP, "R2", 1'b0);
    do_fetch(32'hFFFF_FFFC, K_HIT, "R2", 1'b0);
    do_fetch(32'h0000_0108, K_HIT, "R7", 1'b0);
    check_counts("R10", 4, 2, 4);
  endtask

  task automatic t_busy_ignored();
    do_fetch(32'h0000_0450, K_BYP, "R6", 1'b1);
    for (int i = 0; i < 6; i++) begin
      chk(!core_resp_valid && !l1_req_valid, "R9", "no action from ignored request",
          {30'd0, core_resp_valid, l1_req_valid}, 32'd0);
      @(negedge clk);
    end
    check_counts("R9", 4, 2, 5);
    do_fetch(32'h0000_0454, K_HIT, "R7", 1'b0);
    check_counts("R10", 5, 2, 5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_and_hit();
    t_conflict_and_route();
    t_index_edges();
    t_busy_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule